// File: doc/BRIEF.md
# Low-Power Mode and Wake Controller

This block manages a processor core's two power-saving states. A power-save request from the core carries a mode select. One mode is a light state in which only the CPU clock stops. The other is a deep state in which the main oscillator is also switched off. While either state holds, the block gates the CPU clock, the peripheral clocks and the fail-safe low-power clock, watches the wake sources, and brings the core back to execution in the correct order.

There are three kinds of wake source, each treated differently:
- **Prioritised interrupts.** An enabled, pending interrupt wakes the core only when its priority is strictly above the current CPU level, and the core then takes it.
- **Watchdog time-out.** It wakes the core but no interrupt is taken.
- **Reset strobes.** Power-on, brown-out and pin reset return the block to Run at once and do not raise the resume strobe.

Leaving the light state is immediate. Leaving the deep state first restarts the oscillator and waits a fixed start-up count.

Three sticky status flags record how the core came back. Software clears them with a write-one-to-clear strobe.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: Reset state is Run. In Run, `save_req_i` with `save_mode_i`=1 enters Idle and with `save_mode_i`=0 enters Sleep; `cpu_clk_en_o` is low from the cycle after the request edge. A reset strobe in the same cycle keeps the block in Run.
- R2: In Idle, `osc_en_o`=1 and `periph_clk_en_o[k]` follows `periph_idle_run_i[k]`. In Sleep, `osc_en_o`=0 and all peripheral clocks are gated. In the oscillator start-up phase the CPU and peripheral clocks stay gated. In Run, all clocks are enabled.
- R3: `lprc_clk_en_o` equals `cfd_en_i` in every state except Sleep, where it is 0.
- R4: An interrupt i can wake the core only when `irq_en_i[i]`=1, `irq_pend_i[i]`=1 and its priority field `irq_prio_i[i*PRIO_W +: PRIO_W]` is greater than `cpu_prio_i`. Any other pending interrupt leaves the low-power state unchanged.
- R5: A wake from Idle by interrupt or watchdog raises `cpu_clk_en_o` and a one-cycle `resume_o` in the cycle after the wake edge. `take_irq_o` is high alongside `resume_o` when an interrupt caused the wake.
- R6: A wake from Sleep re-enables the oscillator in the next cycle. `cpu_clk_en_o` and `resume_o` then rise exactly OST_CYCLES cycles later, and `take_irq_o` reflects the wake cause as in R5.
- R7: Any of `por_i`, `bor_i` or `mclr_i` returns the block to Run in the next cycle, from any state, without `resume_o`.
- R8: `stat_o` uses bit 0 for sleep-wake, bit 1 for idle-wake and bit 2 for watchdog-wake. A wake from Idle sets bit 1, a wake from Sleep sets bit 0, and a watchdog wake also sets bit 2. All of these bits are set in the cycle after the wake edge.
- R9: `por_i` clears all of `stat_o`, taking precedence over everything else. `bor_i` or `mclr_i` without `por_i` sets bit 1.
- R10: Status bits are sticky. A 1 in `stat_clr_i[b]` clears bit b, but a set event in the same cycle wins.
- R11: `save_req_i` is ignored while in Idle, Sleep or start-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on control clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| save_req_i | input | 1 | Power-save request strobe from the core |
| save_mode_i | input | 1 | 1 = Idle, 0 = Sleep |
| irq_en_i | input | N_IRQ | Interrupt enable bits |
| irq_pend_i | input | N_IRQ | Interrupt pending flags |
| irq_prio_i | input | N_IRQ*PRIO_W | Packed per-interrupt priorities |
| cpu_prio_i | input | PRIO_W | Current CPU priority level |
| wdt_to_i | input | 1 | Watchdog time-out strobe |
| por_i | input | 1 | Power-on reset strobe |
| bor_i | input | 1 | Brown-out reset strobe |
| mclr_i | input | 1 | External pin reset strobe |
| periph_idle_run_i | input | N_PERIPH | Per-peripheral keep-running-in-Idle controls |
| cfd_en_i | input | 1 | Clock-failure detection enabled |
| stat_clr_i | input | 3 | Write-one-to-clear strobes for `stat_o` |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| osc_en_o | output | 1 | Main oscillator enable |
| lprc_clk_en_o | output | 1 | Fail-safe low-power clock enable |
| periph_clk_en_o | output | N_PERIPH | Peripheral clock enables |
| resume_o | output | 1 | One-cycle strobe: execution resumes |
| take_irq_o | output | 1 | With `resume_o`: the core takes the waking interrupt |
| stat_o | output | 3 | Sticky wake status {wdt, idle, sleep} |

## Verification
The checker enforces these rules on every cycle:
- a resume never occurs with the CPU clock gated;
- a low-power state never changes without a qualified wake or reset;
- a reset strobe always lands in Run without a resume;
- a power-on reset leaves the flags cleared;
- flags never drop without a clear or power-on reset;
- the oscillator-off state gates every other clock.

The exact start-up count after Sleep can only be shown by the bench's scenarios. The same holds for the following: the peripheral pattern in Idle, the priority threshold at equality, which flag each wake path sets, set-over-clear and the ignored second request.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_IDLE  = 2'd1,
    ST_SLEEP = 2'd2,
    ST_OST   = 2'd3
  } pw_state_e;

  localparam int STAT_W    = 3;
  localparam int STAT_SLP  = 0;
  localparam int STAT_IDL  = 1;
  localparam int STAT_WDT  = 2;
endpackage

// File: rtl/pwr_wake_arb.sv
module pwr_wake_arb #(
  parameter int N_IRQ  = 8,
  parameter int PRIO_W = 3
) (
  input  logic [N_IRQ-1:0]        irq_en_i,
  input  logic [N_IRQ-1:0]        irq_pend_i,
  input  logic [N_IRQ*PRIO_W-1:0] irq_prio_i,
  input  logic [PRIO_W-1:0]       cpu_prio_i,
  output logic                    wake_o
);
  logic [N_IRQ-1:0] hit;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
    assign hit[i] = irq_en_i[i] & irq_pend_i[i] &
                    (irq_prio_i[i*PRIO_W +: PRIO_W] > cpu_prio_i);
  end

  assign wake_o = |hit;
endmodule

// File: rtl/pwr_wake_fsm.sv
module pwr_wake_fsm
  import pwr_wake_pkg::*;
#(
  parameter int OST_CYCLES = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      save_req_i,
  input  logic      save_mode_i,
  input  logic      irq_wake_i,
  input  logic      wdt_to_i,
  input  logic      rst_evt_i,
  output pw_state_e st_o,
  output logic      resume_o,
  output logic      take_irq_o
);
  localparam int CNT_W = $clog2(OST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OST_CYCLES - 1);

  pw_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tp_q, tp_d;
  logic             res_q, res_d;
  logic             take_q, take_d;
  logic             wake;

  assign wake = irq_wake_i | wdt_to_i;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    tp_d   = tp_q;
    res_d  = 1'b0;
    take_d = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (save_req_i && !rst_evt_i) st_d = save_mode_i ? ST_IDLE : ST_SLEEP;
      end
      ST_IDLE: begin
        if (rst_evt_i) begin
          st_d = ST_RUN;
        end else if (wake) begin
          st_d   = ST_RUN;
          res_d  = 1'b1;
          take_d = irq_wake_i;
        end
      end
      ST_SLEEP: begin
        if (rst_evt_i) begin
          st_d = ST_RUN;
        end else if (wake) begin
          st_d  = ST_OST;
          cnt_d = '0;
          tp_d  = irq_wake_i;
        end
      end
      ST_OST: begin
        if (rst_evt_i) begin
          st_d = ST_RUN;
          tp_d = 1'b0;
        end else if (cnt_q == CNT_LAST) begin
          st_d   = ST_RUN;
          res_d  = 1'b1;
          take_d = tp_q;
          tp_d   = 1'b0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_RUN;
      cnt_q  <= '0;
      tp_q   <= 1'b0;
      res_q  <= 1'b0;
      take_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      tp_q   <= tp_d;
      res_q  <= res_d;
      take_q <= take_d;
    end
  end

  assign st_o       = st_q;
  assign resume_o   = res_q;
  assign take_irq_o = take_q;
endmodule

// File: rtl/pwr_wake_status.sv
module pwr_wake_status
  import pwr_wake_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  pw_state_e         st_i,
  input  logic              irq_wake_i,
  input  logic              wdt_to_i,
  input  logic              por_i,
  input  logic              bor_i,
  input  logic              mclr_i,
  input  logic [STAT_W-1:0] clr_i,
  output logic [STAT_W-1:0] stat_o
);
  logic [STAT_W-1:0] stat_q, set;
  logic              rst_evt, lp_wake, in_idle, in_sleep;

  assign rst_evt  = por_i | bor_i | mclr_i;
  assign in_idle  = (st_i == ST_IDLE);
  assign in_sleep = (st_i == ST_SLEEP);
  assign lp_wake  = (irq_wake_i | wdt_to_i) & ~rst_evt;

  always_comb begin
    set           = '0;
    set[STAT_IDL] = (in_idle & lp_wake) | bor_i | mclr_i;
    set[STAT_SLP] = in_sleep & lp_wake;
    set[STAT_WDT] = (in_idle | in_sleep) & wdt_to_i & ~rst_evt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    stat_q <= '0;
    else if (por_i) stat_q <= '0;
    else            stat_q <= (stat_q & ~clr_i) | set;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/pwr_wake_clkgate.sv
module pwr_wake_clkgate
  import pwr_wake_pkg::*;
#(
  parameter int N_PERIPH = 4
) (
  input  pw_state_e           st_i,
  input  logic [N_PERIPH-1:0] periph_idle_run_i,
  input  logic                cfd_en_i,
  output logic                cpu_clk_en_o,
  output logic                osc_en_o,
  output logic                lprc_clk_en_o,
  output logic [N_PERIPH-1:0] periph_clk_en_o
);
  logic in_run, in_idle;

  assign in_run        = (st_i == ST_RUN);
  assign in_idle       = (st_i == ST_IDLE);
  assign cpu_clk_en_o  = in_run;
  assign osc_en_o      = (st_i != ST_SLEEP);
  assign lprc_clk_en_o = cfd_en_i & (st_i != ST_SLEEP);

  for (genvar k = 0; k < N_PERIPH; k++) begin : g_per
    assign periph_clk_en_o[k] = in_run | (in_idle & periph_idle_run_i[k]);
  end
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
  import pwr_wake_pkg::*;
#(
  parameter int N_IRQ      = 8,
  parameter int PRIO_W     = 3,
  parameter int N_PERIPH   = 4,
  parameter int OST_CYCLES = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    save_req_i,
  input  logic                    save_mode_i,
  input  logic [N_IRQ-1:0]        irq_en_i,
  input  logic [N_IRQ-1:0]        irq_pend_i,
  input  logic [N_IRQ*PRIO_W-1:0] irq_prio_i,
  input  logic [PRIO_W-1:0]       cpu_prio_i,
  input  logic                    wdt_to_i,
  input  logic                    por_i,
  input  logic                    bor_i,
  input  logic                    mclr_i,
  input  logic [N_PERIPH-1:0]     periph_idle_run_i,
  input  logic                    cfd_en_i,
  input  logic [2:0]              stat_clr_i,
  output logic                    cpu_clk_en_o,
  output logic                    osc_en_o,
  output logic                    lprc_clk_en_o,
  output logic [N_PERIPH-1:0]     periph_clk_en_o,
  output logic                    resume_o,
  output logic                    take_irq_o,
  output logic [2:0]              stat_o
);
  pw_state_e st_q;
  logic      irq_wake;
  logic      rst_evt;

  assign rst_evt = por_i | bor_i | mclr_i;

  pwr_wake_arb #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) u_arb (
    .irq_en_i   (irq_en_i),
    .irq_pend_i (irq_pend_i),
    .irq_prio_i (irq_prio_i),
    .cpu_prio_i (cpu_prio_i),
    .wake_o     (irq_wake)
  );

  pwr_wake_fsm #(.OST_CYCLES(OST_CYCLES)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .save_req_i  (save_req_i),
    .save_mode_i (save_mode_i),
    .irq_wake_i  (irq_wake),
    .wdt_to_i    (wdt_to_i),
    .rst_evt_i   (rst_evt),
    .st_o        (st_q),
    .resume_o    (resume_o),
    .take_irq_o  (take_irq_o)
  );

  pwr_wake_status u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .st_i       (st_q),
    .irq_wake_i (irq_wake),
    .wdt_to_i   (wdt_to_i),
    .por_i      (por_i),
    .bor_i      (bor_i),
    .mclr_i     (mclr_i),
    .clr_i      (stat_clr_i),
    .stat_o     (stat_o)
  );

  pwr_wake_clkgate #(.N_PERIPH(N_PERIPH)) u_cg (
    .st_i              (st_q),
    .periph_idle_run_i (periph_idle_run_i),
    .cfd_en_i          (cfd_en_i),
    .cpu_clk_en_o      (cpu_clk_en_o),
    .osc_en_o          (osc_en_o),
    .lprc_clk_en_o     (lprc_clk_en_o),
    .periph_clk_en_o   (periph_clk_en_o)
  );
endmodule

// File: rtl/pwr_wake_chk.sv
module pwr_wake_chk
  import pwr_wake_pkg::*;
#(
  parameter int N_PERIPH = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                save_req_i,
  input logic                wdt_to_i,
  input logic                por_i,
  input logic [2:0]          stat_clr_i,
  input logic                cpu_clk_en_o,
  input logic                osc_en_o,
  input logic                lprc_clk_en_o,
  input logic [N_PERIPH-1:0] periph_clk_en_o,
  input logic                resume_o,
  input logic                take_irq_o,
  input logic [2:0]          stat_o,
  input pw_state_e           st_q,
  input logic                irq_wake,
  input logic                rst_evt
);
  assert_entry_gates_cpu_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && save_req_i && !rst_evt) |=> !cpu_clk_en_o);

  assert_sleep_gates_all_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> (!cpu_clk_en_o && periph_clk_en_o == '0 && !lprc_clk_en_o));

  assert_lprc_needs_osc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lprc_clk_en_o |-> osc_en_o);

  // R4, R11: no qualified wake and no reset means the low-power state holds
  assert_lp_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_IDLE || st_q == ST_SLEEP) && !irq_wake && !wdt_to_i && !rst_evt)
      |=> $stable(st_q));

  assert_idle_irq_wake_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && irq_wake && !rst_evt) |=> (resume_o && take_irq_o && cpu_clk_en_o));

  assert_resume_cpu_on_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |-> cpu_clk_en_o);

  assert_reset_to_run_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_evt |=> (cpu_clk_en_o && !resume_o));

  assert_por_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (stat_o == 3'b000));

  assert_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!por_i && stat_clr_i == 3'b000) |=> ((stat_o & $past(stat_o)) == $past(stat_o)));
endmodule

bind pwr_wake_ctrl pwr_wake_chk #(.N_PERIPH(N_PERIPH)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .save_req_i      (save_req_i),
  .wdt_to_i        (wdt_to_i),
  .por_i           (por_i),
  .stat_clr_i      (stat_clr_i),
  .cpu_clk_en_o    (cpu_clk_en_o),
  .osc_en_o        (osc_en_o),
  .lprc_clk_en_o   (lprc_clk_en_o),
  .periph_clk_en_o (periph_clk_en_o),
  .resume_o        (resume_o),
  .take_irq_o      (take_irq_o),
  .stat_o          (stat_o),
  .st_q            (st_q),
  .irq_wake        (irq_wake),
  .rst_evt         (rst_evt)
);

// File: tb/pwr_wake_ctrl_tb_top.sv
module pwr_wake_ctrl_tb_top;
  localparam int N_IRQ = 8, PRIO_W = 3, N_PERIPH = 4, OST = 16;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic save_req_i = 0, save_mode_i = 0, wdt_to_i = 0, por_i = 0, bor_i = 0, mclr_i = 0;
  logic [N_IRQ-1:0] irq_en_i = '0, irq_pend_i = '0;
  logic [N_IRQ*PRIO_W-1:0] irq_prio_i = '0;
  logic [PRIO_W-1:0] cpu_prio_i = '0;
  logic [N_PERIPH-1:0] periph_idle_run_i = 4'b0101;
  logic cfd_en_i = 1'b1;
  logic [2:0] stat_clr_i = '0;
  logic cpu_clk_en_o, osc_en_o, lprc_clk_en_o, resume_o, take_irq_o;
  logic [N_PERIPH-1:0] periph_clk_en_o;
  logic [2:0] stat_o;

  always #4 clk_i = ~clk_i;

  pwr_wake_ctrl #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W), .N_PERIPH(N_PERIPH), .OST_CYCLES(OST)) dut_i (.*);

  // obs = {cpu, osc, lprc, periph[3:0], resume, take, stat[2:0]}
  localparam logic [11:0] M_ALL = 12'hFFF, M_CPU = 12'h800, M_OSC = 12'h400, M_LPRC = 12'h200,
                          M_PER = 12'h1E0, M_RES = 12'h010, M_TAK = 12'h008, M_ST = 12'h007;

  typedef struct { int cyc; logic [11:0] m; logic [11:0] v; string tag; } exp_t;
  exp_t sb_q[$];
  int cyc = 0, n_cmp = 0, n_bad = 0;
  bit done = 0;

  function automatic logic [11:0] ov(logic c, logic o, logic l, logic [3:0] p,
                                     logic r, logic t, logic [2:0] s);
    return {c, o, l, p, r, t, s};
  endfunction

  task automatic push(int d, logic [11:0] m, logic [11:0] v, string tag);
    exp_t e;
    e.cyc = cyc + d; e.m = m; e.v = v; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic clr_pulses();
    @(negedge clk_i);
    save_req_i = 0; wdt_to_i = 0; por_i = 0; bor_i = 0; mclr_i = 0; stat_clr_i = '0;
  endtask

  // monitor: compares expectations due this cycle, away from the edge
  initial begin
    forever begin
      @(posedge clk_i);
      cyc++;
      #2;
      for (int i = sb_q.size() - 1; i >= 0; i--) begin
        if (sb_q[i].cyc == cyc) begin
          logic [11:0] act;
          act = {cpu_clk_en_o, osc_en_o, lprc_clk_en_o, periph_clk_en_o,
                 resume_o, take_irq_o, stat_o};
          n_cmp++;
          if ((act & sb_q[i].m) != (sb_q[i].v & sb_q[i].m)) begin
            n_bad++;
            $display("FAIL %s cyc=%0d actual=%h expected=%h mask=%h", sb_q[i].tag, cyc,
                     act & sb_q[i].m, sb_q[i].v & sb_q[i].m, sb_q[i].m);
          end
          sb_q.delete(i);
        end
      end
    end
  end

  initial begin
    #(8 * 50000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    irq_prio_i[0*PRIO_W +: PRIO_W] = 3'd3;
    irq_prio_i[1*PRIO_W +: PRIO_W] = 3'd7;
    irq_prio_i[2*PRIO_W +: PRIO_W] = 3'd5;
    cpu_prio_i = 3'd3;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    push(1, M_ALL, ov(1,1,1,4'b1111,0,0,3'b000), "R1 reset state");
    repeat (2) @(negedge clk_i);

    // R1/R2/R3: enter Idle
    save_req_i = 1; save_mode_i = 1;
    push(1, M_ALL, ov(0,1,1,4'b0101,0,0,3'b000), "R2 idle clocks");
    clr_pulses();

    // R4: equal priority and disabled interrupts do not wake
    irq_en_i = 8'b0000_0001; irq_pend_i = 8'b0000_0011;
    push(1, M_CPU | M_OSC, ov(0,1,0,0,0,0,0), "R4 no wake at equal prio");
    push(3, M_CPU | M_RES, 12'h000, "R4 still idle");
    repeat (3) @(negedge clk_i);
    // R11: request to Sleep ignored while in Idle
    save_req_i = 1; save_mode_i = 0;
    push(1, M_CPU | M_OSC | M_PER, ov(0,1,0,4'b0101,0,0,0), "R11 second request ignored");
    clr_pulses();
    repeat (2) @(negedge clk_i);

    // R5/R8: interrupt above CPU level wakes Idle immediately
    irq_en_i = 8'b0000_0101; irq_pend_i = 8'b0000_0100;
    push(1, M_ALL, ov(1,1,1,4'b1111,1,1,3'b010), "R5 idle irq wake");
    push(2, M_RES | M_TAK, 12'h000, "R5 resume one cycle");
    @(negedge clk_i); irq_pend_i = '0;
    @(negedge clk_i);

    // R10: software clear
    stat_clr_i = 3'b010;
    push(1, M_ST, 12'h000, "R10 clear idle flag");
    clr_pulses();

    // R2/R3: enter Sleep
    save_req_i = 1; save_mode_i = 0;
    push(1, M_ALL, ov(0,0,0,4'b0000,0,0,3'b000), "R2 sleep clocks");
    clr_pulses();
    repeat (2) @(negedge clk_i);

    // R6/R8: watchdog wake from Sleep with start-up delay
    wdt_to_i = 1;
    push(1, M_CPU | M_OSC | M_PER | M_ST, ov(0,1,0,4'b0000,0,0,3'b101), "R6 osc back, R8 flags");
    push(OST, M_CPU | M_RES, 12'h000, "R6 still starting");
    push(OST + 1, M_CPU | M_RES | M_TAK, ov(1,0,0,0,1,0,0), "R6 resume after start-up");
    clr_pulses();
    repeat (OST + 2) @(negedge clk_i);

    // R6: interrupt wake from Sleep, taken at resume
    stat_clr_i = 3'b111;
    clr_pulses();
    save_req_i = 1; save_mode_i = 0;
    clr_pulses();
    irq_pend_i = 8'b0000_0100;
    push(1, M_ST | M_OSC, ov(0,1,0,0,0,0,3'b001), "R8 sleep flag only");
    push(OST + 1, M_CPU | M_RES | M_TAK, ov(1,0,0,0,1,1,0), "R6 irq taken after start-up");
    @(negedge clk_i); irq_pend_i = '0;
    repeat (OST + 2) @(negedge clk_i);

    // R5/R8: watchdog wake from Idle
    stat_clr_i = 3'b111;
    clr_pulses();
    save_req_i = 1; save_mode_i = 1;
    clr_pulses();
    wdt_to_i = 1;
    push(1, M_CPU | M_RES | M_TAK | M_ST, ov(1,0,0,0,1,0,3'b110), "R5 idle wdt wake");
    clr_pulses();

    // R7/R9: pin reset in Idle
    stat_clr_i = 3'b111;
    clr_pulses();
    save_req_i = 1; save_mode_i = 1;
    clr_pulses();
    mclr_i = 1;
    push(1, M_CPU | M_RES | M_ST, ov(1,0,0,0,0,0,3'b010), "R7 reset wakes no resume, R9 idle flag");
    clr_pulses();

    // R9: power-on reset clears, wins over brown-out
    por_i = 1; bor_i = 1;
    push(1, M_ST, 12'h000, "R9 por clears");
    clr_pulses();
    bor_i = 1;
    push(1, M_ST, ov(0,0,0,0,0,0,3'b010), "R9 bor sets idle flag");
    clr_pulses();

    // R7: reset strobe in Sleep
    save_req_i = 1; save_mode_i = 0;
    clr_pulses();
    bor_i = 1;
    push(1, M_CPU | M_OSC | M_RES, ov(1,1,0,0,0,0,0), "R7 reset leaves sleep");
    clr_pulses();

    // R1: reset strobe beside a request keeps Run
    save_req_i = 1; save_mode_i = 1; mclr_i = 1;
    push(1, M_CPU, M_CPU, "R1 reset beats request");
    clr_pulses();

    // R10: set wins over clear in the same cycle
    por_i = 1;
    clr_pulses();
    save_req_i = 1; save_mode_i = 1;
    clr_pulses();
    wdt_to_i = 1; stat_clr_i = 3'b111;
    push(1, M_ST, ov(0,0,0,0,0,0,3'b110), "R10 set wins over clear");
    clr_pulses();

    // R3: fail-safe clock follows detection enable
    cfd_en_i = 1'b0;
    push(1, M_LPRC, 12'h000, "R3 lprc off when detection off");
    repeat (4) @(negedge clk_i);

    if (sb_q.size() != 0) begin
      n_bad += sb_q.size();
      $display("FAIL scoreboard actual=%0d pending expected=0", sb_q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule